// File: doc/BRIEF.md
# Per-Layer Scanline True-Point Classifier

This block sits between the merge stage of a Manhattan layout rule checker and its width/spacing checker. It takes one stream of edge endpoints that have already been merged into canonical order along the current scanline. A marker point on layer 0 opens each scanline. Every layer has two up/down counters, one for the region to the left of the scanline and one for the region to the right. The block uses them to find which points lie on the boundary of the union of overlapping shapes. Each point goes to the checker tagged as a true point, a true endpoint, a virtual point or a scanline marker.

In the same cycle the block builds the stream for the next scanline. A starting endpoint becomes an inherited (old) point. Old points and virtual points already in the stream are passed on unchanged, because the merge stage retires and ages them. A true ending endpoint that meets the spacing or width condition starts a new virtual point, whose reach comes from a per-layer extension value. A decrement past zero means the endpoint stream is malformed, and the block flags it.

Top module: `scan_truept_classifier`

## Requirements
- R1: Each input point appears on the checker output exactly one cycle later, with Y, layer, orientation, D, P and extension unchanged. With no input, both output valids stay low.
- R2: A point's kind comes from {P,D}: 00 starting endpoint, 01 ending endpoint, 11 old point, 10 virtual point. For a forward point (orientation 0), an old point raises both the left and right counters of its layer, a starting endpoint raises only the right counter, and an ending endpoint raises only the left counter.
- R3: For a backward point (orientation 1), the same three kinds lower the same counters by one.
- R4: A side counts as inside when its counter is above zero. A point is tagged true when the inside/outside state changes on at least one side. It is tagged a true endpoint when the state changes on exactly one side.
- R5: A decrement of a counter that is already zero raises the underflow flag with that point, and the counter stays at zero.
- R6: A point on layer 0 is a scanline marker. It clears every layer's counters, is tagged as a marker and not as true, and is not carried to the next scanline.
- R7: A starting endpoint is carried to the next scanline as an old point: P=1 and D=1, with Y, layer, orientation and extension kept.
- R8: Incoming old points and virtual points are carried to the next scanline unchanged.
- R9: A new virtual point (P=1, D=0, same Y, layer and orientation) is carried in two cases: for a forward true ending endpoint whose right counter is zero after its update, and for a backward true ending endpoint whose right counter is above zero after its update. Its extension is EXT_BASE + EXT_STEP x layer (defaults 3 and 3). No other ending endpoint is carried.
- R10: A virtual point is tagged virtual, never true, and leaves all counters untouched.
- R11: The counters of one layer are independent of points on any other layer.
- R12: After reset all counters are zero and both output valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Merged input point present |
| in_y | input | Y_W | Point Y coordinate (X value for a marker) |
| in_layer | input | L_W | Layer, 0 marks a scanline boundary |
| in_o | input | 1 | Orientation, 0 forward, 1 backward |
| in_d | input | 1 | D bit of the point kind |
| in_p | input | 1 | P bit of the point kind |
| in_xext | input | X_W | Remaining extension of a virtual point |
| chk_valid | output | 1 | Tagged point to the checker present |
| chk_y | output | Y_W | Tagged point Y |
| chk_layer | output | L_W | Tagged point layer |
| chk_o | output | 1 | Tagged point orientation |
| chk_d | output | 1 | Tagged point D bit |
| chk_p | output | 1 | Tagged point P bit |
| chk_xext | output | X_W | Tagged point extension |
| chk_true | output | 1 | Point lies on the union boundary |
| chk_tend | output | 1 | Boundary changes on exactly one side |
| chk_virtual | output | 1 | Point is a virtual point |
| chk_marker | output | 1 | Point is a scanline marker |
| err_underflow | output | 1 | A counter would have gone below zero |
| nxt_valid | output | 1 | Point for the next scanline present |
| nxt_y | output | Y_W | Carried point Y |
| nxt_layer | output | L_W | Carried point layer |
| nxt_o | output | 1 | Carried point orientation |
| nxt_d | output | 1 | Carried point D bit |
| nxt_p | output | 1 | Carried point P bit |
| nxt_xext | output | X_W | Carried point extension |

## Verification
Several things happen for a single true ending endpoint in the same cycle. It is tagged for the checker from its counter update, and the right-side count after that update also decides whether it starts a virtual point for the next scanline. The bench sends forward and backward ending endpoints whose right counter ends either empty or occupied. It then judges the tag bits and the presence, fields and extension of the carried point on the same output cycle. An underflowing decrement is also combined with a true tag in one cycle. A later point on that layer then shows the counter held at zero rather than wrapped.

// File: rtl/scan_truept_pkg.sv
// Package: point kinds shared by the classifier modules.
// Assumes the kind is fully encoded by the P and D bits of a point.
package scan_truept_pkg;

    typedef enum logic [1:0] {
        KIND_START = 2'b00,
        KIND_END   = 2'b01,
        KIND_VIRT  = 2'b10,
        KIND_OLD   = 2'b11
    } pt_kind_e;

    // Map the {P,D} pair onto a point kind.
    function automatic pt_kind_e kind_of(input logic p, input logic d);
        return pt_kind_e'({p, d});
    endfunction

endpackage

// File: rtl/scan_truept_classify.sv
// Module: scan_truept_classify
// Computes the next left/right counts for one point and its boundary tags.
// Assumes the caller suppresses writes for markers and virtual points.
// Counters saturate at zero (underflow reported) and at their maximum.
module scan_truept_classify
    import scan_truept_pkg::*;
#(
    parameter int C_W = 8
) (
    input  logic [C_W-1:0] lc_cur,
    input  logic [C_W-1:0] rc_cur,
    input  logic           o,
    input  pt_kind_e       kind,
    output logic [C_W-1:0] lc_nxt,
    output logic [C_W-1:0] rc_nxt,
    output logic           is_true,
    output logic           is_tend,
    output logic           uflow
);
    localparam logic [C_W-1:0] CMAX = {C_W{1'b1}};

    logic touch_l, touch_r, chg_l, chg_r, uf_l, uf_r;

    // Choose which sides the point moves and apply the step.
    always_comb begin
        touch_l = (kind == KIND_OLD) || (kind == KIND_END);
        touch_r = (kind == KIND_OLD) || (kind == KIND_START);
        lc_nxt  = lc_cur;
        rc_nxt  = rc_cur;
        uf_l    = 1'b0;
        uf_r    = 1'b0;
        if (touch_l) begin
            if (o) begin
                if (lc_cur == '0) uf_l = 1'b1;
                else              lc_nxt = lc_cur - 1'b1;
            end else if (lc_cur != CMAX) begin
                lc_nxt = lc_cur + 1'b1;
            end
        end
        if (touch_r) begin
            if (o) begin
                if (rc_cur == '0) uf_r = 1'b1;
                else              rc_nxt = rc_cur - 1'b1;
            end else if (rc_cur != CMAX) begin
                rc_nxt = rc_cur + 1'b1;
            end
        end
    end

    // Compare inside/outside state before and after the step.
    always_comb begin
        chg_l   = (lc_cur != '0) != (lc_nxt != '0);
        chg_r   = (rc_cur != '0) != (rc_nxt != '0);
        is_true = chg_l | chg_r;
        is_tend = chg_l ^ chg_r;
        uflow   = uf_l | uf_r;
    end

endmodule

// File: rtl/scan_truept_ctr_bank.sv
// Module: scan_truept_ctr_bank
// Holds a left and a right counter for every layer.
// Assumes clr and wr_en are never asserted together; clr wins if they are.
module scan_truept_ctr_bank #(
    parameter int L_W = 3,
    parameter int C_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           wr_en,
    input  logic [L_W-1:0] layer,
    input  logic [C_W-1:0] lc_wr,
    input  logic [C_W-1:0] rc_wr,
    output logic [C_W-1:0] lc_rd,
    output logic [C_W-1:0] rc_rd
);
    localparam int NL = 1 << L_W;

    logic [C_W-1:0] lc_q [NL];
    logic [C_W-1:0] rc_q [NL];

    for (genvar g = 0; g < NL; g++) begin : g_layer
        // Clear on reset or marker, load on a write to this layer.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                lc_q[g] <= '0;
                rc_q[g] <= '0;
            end else if (wr_en && (layer == L_W'(g))) begin
                lc_q[g] <= lc_wr;
                rc_q[g] <= rc_wr;
            end
        end
    end

    // Present the addressed layer's counts.
    always_comb begin
        lc_rd = lc_q[layer];
        rc_rd = rc_q[layer];
    end

endmodule

// File: rtl/scan_truept_carry.sv
// Module: scan_truept_carry
// Builds the point handed to the next scanline, if any.
// Assumes is_true and rc_inside come from the same point's classification.
module scan_truept_carry
    import scan_truept_pkg::*;
#(
    parameter int X_W = 8
) (
    input  pt_kind_e       kind,
    input  logic           marker,
    input  logic           o,
    input  logic           is_true,
    input  logic           rc_inside,
    input  logic [X_W-1:0] xext_in,
    input  logic [X_W-1:0] ext_new,
    output logic           c_valid,
    output logic           c_d,
    output logic           c_p,
    output logic [X_W-1:0] c_xext
);
    logic spawn;

    // Decide whether and how the point travels to the next scanline.
    always_comb begin
        spawn   = is_true && (o ? rc_inside : !rc_inside);
        c_valid = 1'b0;
        c_d     = 1'b1;
        c_p     = 1'b1;
        c_xext  = xext_in;
        if (!marker) begin
            unique case (kind)
                KIND_START: c_valid = 1'b1;
                KIND_OLD: c_valid = 1'b1;
                KIND_VIRT: begin
                    c_valid = 1'b1;
                    c_d     = 1'b0;
                end
                KIND_END: begin
                    c_valid = spawn;
                    c_d     = 1'b0;
                    c_xext  = ext_new;
                end
                default: c_valid = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/scan_truept_classifier.sv
// Module: scan_truept_classifier
// Tags merged scanline points as boundary points of the per-layer union
// and produces the carried-over stream for the next scanline.
// Assumes input arrives in canonical order, each scanline opened by a
// layer-0 marker. One point per cycle, outputs registered (1 cycle latency).
module scan_truept_classifier
    import scan_truept_pkg::*;
#(
    parameter int Y_W      = 18,
    parameter int L_W      = 3,
    parameter int X_W      = 8,
    parameter int C_W      = 8,
    parameter int EXT_BASE = 3,
    parameter int EXT_STEP = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [Y_W-1:0] in_y,
    input  logic [L_W-1:0] in_layer,
    input  logic           in_o,
    input  logic           in_d,
    input  logic           in_p,
    input  logic [X_W-1:0] in_xext,
    output logic           chk_valid,
    output logic [Y_W-1:0] chk_y,
    output logic [L_W-1:0] chk_layer,
    output logic           chk_o,
    output logic           chk_d,
    output logic           chk_p,
    output logic [X_W-1:0] chk_xext,
    output logic           chk_true,
    output logic           chk_tend,
    output logic           chk_virtual,
    output logic           chk_marker,
    output logic           err_underflow,
    output logic           nxt_valid,
    output logic [Y_W-1:0] nxt_y,
    output logic [L_W-1:0] nxt_layer,
    output logic           nxt_o,
    output logic           nxt_d,
    output logic           nxt_p,
    output logic [X_W-1:0] nxt_xext
);
    pt_kind_e       kind;
    logic           marker, is_virt, wr_en, clr;
    logic [C_W-1:0] lc_rd, rc_rd, lc_nxt, rc_nxt;
    logic           is_true, is_tend, uflow;
    logic           c_valid, c_d, c_p;
    logic [X_W-1:0] c_xext, ext_new;

    // Decode the incoming point and derive bank controls.
    always_comb begin
        kind    = kind_of(in_p, in_d);
        marker  = (in_layer == '0);
        is_virt = (kind == KIND_VIRT);
        clr     = in_valid && marker;
        wr_en   = in_valid && !marker && !is_virt;
        ext_new = X_W'(EXT_BASE + EXT_STEP * int'(in_layer));
    end

    scan_truept_ctr_bank #(.L_W(L_W), .C_W(C_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .wr_en (wr_en),
        .layer (in_layer),
        .lc_wr (lc_nxt),
        .rc_wr (rc_nxt),
        .lc_rd (lc_rd),
        .rc_rd (rc_rd)
    );

    scan_truept_classify #(.C_W(C_W)) u_class (
        .lc_cur  (lc_rd),
        .rc_cur  (rc_rd),
        .o       (in_o),
        .kind    (kind),
        .lc_nxt  (lc_nxt),
        .rc_nxt  (rc_nxt),
        .is_true (is_true),
        .is_tend (is_tend),
        .uflow   (uflow)
    );

    scan_truept_carry #(.X_W(X_W)) u_carry (
        .kind      (kind),
        .marker    (marker),
        .o         (in_o),
        .is_true   (is_true),
        .rc_inside (rc_nxt != '0),
        .xext_in   (in_xext),
        .ext_new   (ext_new),
        .c_valid   (c_valid),
        .c_d       (c_d),
        .c_p       (c_p),
        .c_xext    (c_xext)
    );

    // Register the tagged point for the checker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_valid     <= 1'b0;
            chk_y         <= '0;
            chk_layer     <= '0;
            chk_o         <= 1'b0;
            chk_d         <= 1'b0;
            chk_p         <= 1'b0;
            chk_xext      <= '0;
            chk_true      <= 1'b0;
            chk_tend      <= 1'b0;
            chk_virtual   <= 1'b0;
            chk_marker    <= 1'b0;
            err_underflow <= 1'b0;
        end else begin
            chk_valid     <= in_valid;
            chk_y         <= in_y;
            chk_layer     <= in_layer;
            chk_o         <= in_o;
            chk_d         <= in_d;
            chk_p         <= in_p;
            chk_xext      <= in_xext;
            chk_true      <= in_valid && wr_en && is_true;
            chk_tend      <= in_valid && wr_en && is_tend;
            chk_virtual   <= in_valid && !marker && is_virt;
            chk_marker    <= in_valid && marker;
            err_underflow <= wr_en && uflow;
        end
    end

    // Register the carried point for the next-scanline buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_valid <= 1'b0;
            nxt_y     <= '0;
            nxt_layer <= '0;
            nxt_o     <= 1'b0;
            nxt_d     <= 1'b0;
            nxt_p     <= 1'b0;
            nxt_xext  <= '0;
        end else begin
            nxt_valid <= in_valid && c_valid;
            nxt_y     <= in_y;
            nxt_layer <= in_layer;
            nxt_o     <= in_o;
            nxt_d     <= c_d;
            nxt_p     <= c_p;
            nxt_xext  <= c_xext;
        end
    end

    // R1
    chk_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> chk_valid);
    // R1
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid || nxt_valid) |-> $past(in_valid));
    // R4
    tend_is_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_tend |-> chk_true);
    // R10
    virt_not_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_virtual |-> (!chk_true && !err_underflow));
    // R6
    marker_not_carried_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_marker |-> (!nxt_valid && !chk_true));
    // R7
    carried_p_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_valid |-> nxt_p);
    // R5
    uflow_context_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |-> (chk_valid && chk_o && !chk_marker));

endmodule

// File: tb/scan_truept_classifier_tb.sv
module scan_truept_classifier_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [17:0] in_y = '0;
    logic [2:0]  in_layer = '0;
    logic        in_o = 1'b0, in_d = 1'b0, in_p = 1'b0;
    logic [7:0]  in_xext = '0;
    logic        chk_valid, chk_o, chk_d, chk_p, chk_true, chk_tend;
    logic        chk_virtual, chk_marker, err_underflow;
    logic [17:0] chk_y;
    logic [2:0]  chk_layer;
    logic [7:0]  chk_xext;
    logic        nxt_valid, nxt_o, nxt_d, nxt_p;
    logic [17:0] nxt_y;
    logic [2:0]  nxt_layer;
    logic [7:0]  nxt_xext;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    scan_truept_classifier u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_y(in_y),
        .in_layer(in_layer), .in_o(in_o), .in_d(in_d), .in_p(in_p),
        .in_xext(in_xext), .chk_valid(chk_valid), .chk_y(chk_y),
        .chk_layer(chk_layer), .chk_o(chk_o), .chk_d(chk_d), .chk_p(chk_p),
        .chk_xext(chk_xext), .chk_true(chk_true), .chk_tend(chk_tend),
        .chk_virtual(chk_virtual), .chk_marker(chk_marker),
        .err_underflow(err_underflow), .nxt_valid(nxt_valid), .nxt_y(nxt_y),
        .nxt_layer(nxt_layer), .nxt_o(nxt_o), .nxt_d(nxt_d), .nxt_p(nxt_p),
        .nxt_xext(nxt_xext)
    );

    task automatic ck(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one point for one cycle; outputs are valid at the return.
    task automatic feed(input int y, input int layer, input int o,
                        input int d, input int p, input int xext);
        @(negedge clk);
        in_valid = 1'b1;
        in_y = 18'(y);
        in_layer = 3'(layer);
        in_o = 1'(o);
        in_d = 1'(d);
        in_p = 1'(p);
        in_xext = 8'(xext);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic tags(input string req, input int tr, input int te,
                        input int nv);
        ck({req, " true"}, int'(chk_true), tr);
        ck({req, " tend"}, int'(chk_tend), te);
        ck({req, " nxt_valid"}, int'(nxt_valid), nv);
    endtask

    task automatic t_reset();
        @(negedge clk);
        ck("R12 chk_valid", int'(chk_valid), 0);
        ck("R12 nxt_valid", int'(nxt_valid), 0);
        feed(0, 1, 1, 0, 0, 0); // backward start on cleared counter
        ck("R12 zero counters underflow", int'(err_underflow), 1);
        @(negedge clk);
        ck("R1 idle chk_valid", int'(chk_valid), 0);
    endtask

    task automatic t_forward_rect();
        feed(100, 0, 0, 0, 0, 0);
        ck("R6 marker tag", int'(chk_marker), 1);
        tags("R6 marker", 0, 0, 0);
        feed(10, 1, 0, 0, 0, 0);
        ck("R1 y echo", int'(chk_y), 10);
        ck("R1 layer echo", int'(chk_layer), 1);
        tags("R2 fwd start", 1, 1, 1);
        ck("R7 old d", int'(nxt_d), 1);
        ck("R7 old p", int'(nxt_p), 1);
        ck("R7 old y", int'(nxt_y), 10);
        feed(20, 1, 1, 0, 0, 0);
        tags("R3 bwd start", 1, 1, 1);
        ck("R7 old o", int'(nxt_o), 1);
        feed(101, 0, 0, 0, 0, 0);
        feed(10, 1, 0, 1, 1, 0);
        tags("R2 fwd old", 1, 0, 1);
        ck("R8 old d", int'(nxt_d), 1);
        feed(20, 1, 1, 1, 1, 0);
        tags("R3 bwd old", 1, 0, 1);
        ck("R5 no underflow", int'(err_underflow), 0);
    endtask

    task automatic t_end_virtual();
        feed(102, 0, 0, 0, 0, 0);
        feed(10, 1, 0, 1, 0, 0);
        tags("R9 fwd end right outside", 1, 1, 1);
        ck("R9 virt d", int'(nxt_d), 0);
        ck("R9 virt p", int'(nxt_p), 1);
        ck("R9 virt o", int'(nxt_o), 0);
        ck("R9 virt y", int'(nxt_y), 10);
        ck("R9 virt ext layer1", int'(nxt_xext), 6);
        feed(20, 1, 1, 1, 0, 0);
        tags("R9 bwd end right outside", 1, 1, 0);
        feed(103, 0, 0, 0, 0, 0);
        feed(0, 3, 0, 1, 1, 0);
        feed(4, 3, 1, 1, 0, 0);
        tags("R9 bwd end right inside", 1, 1, 1);
        ck("R9 virt ext layer3", int'(nxt_xext), 12);
        ck("R9 virt o bwd", int'(nxt_o), 1);
        feed(8, 3, 1, 1, 1, 0);
        ck("R5 underflow flag", int'(err_underflow), 1);
        tags("R5 underflow tags", 1, 1, 1);
        feed(9, 3, 0, 1, 0, 0);
        ck("R5 held at zero", int'(chk_true), 1);
    endtask

    task automatic t_overlap();
        feed(104, 0, 0, 0, 0, 0);
        feed(5, 2, 0, 0, 0, 0);
        tags("R4 first fwd", 1, 1, 1);
        feed(7, 2, 0, 0, 0, 0);
        tags("R4 overlap fwd", 0, 0, 1);
        feed(9, 2, 1, 0, 0, 0);
        tags("R4 overlap bwd", 0, 0, 1);
        feed(12, 2, 1, 0, 0, 0);
        tags("R4 last bwd", 1, 1, 1);
    endtask

    task automatic t_virtual_pass();
        feed(105, 0, 0, 0, 0, 0);
        feed(3, 1, 0, 0, 0, 0);
        feed(4, 1, 1, 0, 1, 4);
        ck("R10 virt tag", int'(chk_virtual), 1);
        tags("R10 virt", 0, 0, 1);
        ck("R8 virt d", int'(nxt_d), 0);
        ck("R8 virt ext", int'(nxt_xext), 4);
        ck("R1 ext echo", int'(chk_xext), 4);
        feed(6, 1, 0, 0, 0, 0);
        tags("R10 counter untouched", 0, 0, 1);
    endtask

    task automatic t_layers();
        feed(106, 0, 0, 0, 0, 0);
        feed(1, 1, 0, 0, 0, 0);
        feed(2, 2, 0, 0, 0, 0);
        tags("R11 other layer", 1, 1, 1);
        feed(3, 1, 1, 0, 0, 0);
        tags("R11 own layer", 1, 1, 1);
        feed(107, 0, 0, 0, 0, 0);
        feed(4, 2, 1, 0, 0, 0);
        ck("R6 marker clears", int'(err_underflow), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_forward_rect();
        t_end_virtual();
        t_overlap();
        t_virtual_pass();
        t_layers();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule